// File: doc/BRIEF.md
# Byte-Lane Write and Select Control

This block sits beside a synchronous memory array and decides, at every rising clock edge, which of its four 9-bit byte lanes take a write, whether the device is currently selected, and whether the read-data drivers may be turned on. A single active-low global write strobe writes every lane. A separate active-low gate allows four active-low per-lane strobes to reach the write mask. A three-input select with mixed polarities enables the device. The block also captures the incoming write data into a lane-packed register.

The select decision is captured only on cycles that start a new access (flagged by `addr_load`). Between those cycles it holds, so a burst keeps the select state it started with. While the select flag is low, no lane is written. The output-drive enable is combinational in the asynchronous active-low output enable. It is forced off whenever a lane write is registered. A high `sleep` input freezes every register, and the stored state is kept until sleep drops.

Top module: `lane_write_ctrl`

## Requirements
- R1: When `gwr_n` is low at an awake rising edge and the effective select is high, `lane_wr` becomes 4'b1111 on that edge, whatever `bwgate_n` and `bsel_n` are.
- R2: When `gwr_n` is high and `bwgate_n` is low at an awake edge with the effective select high, `lane_wr[i]` becomes `~bsel_n[i]` for every lane i.
- R3: When `gwr_n` and `bwgate_n` are both high at an awake edge, `lane_wr` becomes 4'b0000, whatever `bsel_n` is.
- R4: At every awake edge, `lane_data` captures the write data with lane i in bits [9i+8:9i]. Bits 9i..9i+7 hold `wr_din[8i+7:8i]`, and bit 9i+8 holds `wr_par[i]`.
- R5: While `lane_wr` is non-zero, `drv_en` is low.
- R6: `drv_en` is high exactly when `oe_n` is low, `sel` is high and `lane_wr` is zero. It follows `oe_n` with no clock edge in between.
- R7: On an awake edge with `addr_load` high, `sel` becomes 1 only if `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. On an awake edge with `addr_load` low, `sel` holds. The effective select for an edge is the newly decoded value when `addr_load` is high, and the held `sel` otherwise.
- R8: When the effective select is low at an awake edge, `lane_wr` becomes 4'b0000 even if `gwr_n` is low.
- R9: While `sleep` is high, no register changes (`lane_wr`, `sel` and `lane_data` keep their values), and `clk_en` equals the inverse of `sleep`.
- R10: After reset, `lane_wr`, `sel` and `lane_data` are zero and `drv_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High freezes all registers |
| addr_load | input | 1 | High on cycles that start a new access |
| ce_n | input | 1 | Active-low chip enable |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| gwr_n | input | 1 | Active-low global write, all lanes |
| bwgate_n | input | 1 | Active-low gate for the per-lane strobes |
| bsel_n | input | 4 | Active-low per-lane write strobes |
| wr_din | input | 32 | Write data, 8 bits per lane |
| wr_par | input | 4 | Parity bit per lane |
| oe_n | input | 1 | Asynchronous active-low output enable |
| lane_wr | output | 4 | Registered lane write mask |
| sel | output | 1 | Registered select flag |
| lane_data | output | 36 | Registered lane-packed write data |
| clk_en | output | 1 | High when the clock is not gated by sleep |
| drv_en | output | 1 | Read-data driver enable |

## Verification
Assertions check on every cycle the properties that follow directly from port values: the full mask under a selected global write, the empty mask when both write strobes are idle, drivers off during any lane write or with `oe_n` high, the zero mask while deselected, select holding between loads, and the register freeze during sleep. The bench scenarios are needed to show the per-lane mapping of the gated strobes and the lane packing of data and parity. They also show that each of the three select inputs alone deselects the device, and that the select state persists across non-loading cycles and across a sleep interval.

// File: rtl/lane_write_pkg.sv
package lane_write_pkg;

    // Source of the lane write mask for one edge
    typedef enum logic [1:0] {
        WSRC_NONE   = 2'd0,
        WSRC_GLOBAL = 2'd1,
        WSRC_LANES  = 2'd2
    } wr_src_e;

endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
    import lane_write_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwgate_n,
    input  logic [LANES-1:0] bsel_n,
    output wr_src_e          src,
    output logic [LANES-1:0] mask
);

    // Global write overrides the gated per-lane strobes
    always_comb begin
        if (!gwr_n) begin
            src = WSRC_GLOBAL;
        end else if (!bwgate_n) begin
            src = WSRC_LANES;
        end else begin
            src = WSRC_NONE;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (src)
                WSRC_GLOBAL: mask[g] = 1'b1;
                WSRC_LANES:  mask[g] = ~bsel_n[g];
                default:     mask[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/chip_sel_decode.sv
module chip_sel_decode (
    input  logic ce_n,
    input  logic cs_hi,
    input  logic cs_lo_n,
    output logic hit
);

    always_comb begin
        hit = (~ce_n) & cs_hi & (~cs_lo_n);
    end

endmodule

// File: rtl/lane_data_pack.sv
module lane_data_pack #(
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8
) (
    input  logic [LANES*LANE_BITS-1:0]     din,
    input  logic [LANES-1:0]               par,
    output logic [LANES*(LANE_BITS+1)-1:0] packed_o
);

    localparam int LANE_W = LANE_BITS + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        always_comb begin
            packed_o[g*LANE_W +: LANE_BITS] = din[g*LANE_BITS +: LANE_BITS];
            packed_o[g*LANE_W + LANE_BITS]  = par[g];
        end
    end

endmodule

// File: rtl/lane_write_ctrl.sv
module lane_write_ctrl
    import lane_write_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sleep,
    input  logic                           addr_load,
    input  logic                           ce_n,
    input  logic                           cs_hi,
    input  logic                           cs_lo_n,
    input  logic                           gwr_n,
    input  logic                           bwgate_n,
    input  logic [LANES-1:0]               bsel_n,
    input  logic [LANES*LANE_BITS-1:0]     wr_din,
    input  logic [LANES-1:0]               wr_par,
    input  logic                           oe_n,
    output logic [LANES-1:0]               lane_wr,
    output logic                           sel,
    output logic [LANES*(LANE_BITS+1)-1:0] lane_data,
    output logic                           clk_en,
    output logic                           drv_en
);

    localparam int LANE_W = LANE_BITS + 1;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [LANES-1:0]  lane_wr;
        logic              sel;
        logic [DATA_W-1:0] data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    wr_src_e           src_w;
    logic [LANES-1:0]  raw_mask_w;
    logic              hit_w;
    logic [DATA_W-1:0] packed_w;

    lane_mask_gen #(.LANES(LANES)) i_mask (
        .gwr_n    (gwr_n),
        .bwgate_n (bwgate_n),
        .bsel_n   (bsel_n),
        .src      (src_w),
        .mask     (raw_mask_w)
    );

    chip_sel_decode i_sel (
        .ce_n    (ce_n),
        .cs_hi   (cs_hi),
        .cs_lo_n (cs_lo_n),
        .hit     (hit_w)
    );

    lane_data_pack #(.LANES(LANES), .LANE_BITS(LANE_BITS)) i_pack (
        .din      (wr_din),
        .par      (wr_par),
        .packed_o (packed_w)
    );

    // Next-state computation
    always_comb begin
        logic sel_eff;
        st_d    = st_q;
        sel_eff = addr_load ? hit_w : st_q.sel;
        if (!sleep) begin
            st_d.sel  = sel_eff;
            st_d.data = packed_w;
            if (sel_eff && (src_w != WSRC_NONE)) begin
                st_d.lane_wr = raw_mask_w;
            end else begin
                st_d.lane_wr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lane_wr   = st_q.lane_wr;
        sel       = st_q.sel;
        lane_data = st_q.data;
        clk_en    = ~sleep;
        drv_en    = (~oe_n) & st_q.sel & ~(|st_q.lane_wr);
    end

endmodule

module lane_write_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             addr_load,
    input logic             ce_n,
    input logic             cs_hi,
    input logic             cs_lo_n,
    input logic             gwr_n,
    input logic             bwgate_n,
    input logic             oe_n,
    input logic [LANES-1:0] lane_wr,
    input logic             sel,
    input logic             drv_en
);

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !gwr_n && addr_load && !ce_n && cs_hi && !cs_lo_n) |=> (lane_wr == '1)); // R1

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && gwr_n && bwgate_n) |=> (lane_wr == '0)); // R3

    AST_WRITE_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr != '0) |-> !drv_en); // R5

    AST_OE_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv_en); // R6

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !addr_load) |=> $stable(sel)); // R7

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (lane_wr == '0)); // R8

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(lane_wr) && $stable(sel))); // R9

endmodule

bind lane_write_ctrl lane_write_ctrl_chk #(.LANES(LANES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .addr_load (addr_load),
    .ce_n      (ce_n),
    .cs_hi     (cs_hi),
    .cs_lo_n   (cs_lo_n),
    .gwr_n     (gwr_n),
    .bwgate_n  (bwgate_n),
    .oe_n      (oe_n),
    .lane_wr   (lane_wr),
    .sel       (sel),
    .drv_en    (drv_en)
);

// File: tb/test_lane_write_ctrl.sv
module test_lane_write_ctrl;

    localparam int LANES     = 4;
    localparam int LANE_BITS = 8;
    localparam int DATA_W    = LANES * (LANE_BITS + 1);

    typedef struct {
        string                 tag;
        logic [LANES-1:0]      mask;
        logic                  sel;
        logic [DATA_W-1:0]     data;
        logic                  drv;
        logic                  cen;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0, addr_load = 1'b0;
    logic ce_n = 1'b1, cs_hi = 1'b0, cs_lo_n = 1'b1;
    logic gwr_n = 1'b1, bwgate_n = 1'b1;
    logic [LANES-1:0] bsel_n = '1;
    logic [LANES*LANE_BITS-1:0] wr_din = '0;
    logic [LANES-1:0] wr_par = '0;
    logic oe_n = 1'b1;
    logic [LANES-1:0] lane_wr;
    logic sel;
    logic [DATA_W-1:0] lane_data;
    logic clk_en, drv_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    logic             m_sel = 1'b0;
    logic [LANES-1:0] m_mask = '0;
    logic [DATA_W-1:0] m_data = '0;

    always #4 clk = ~clk;

    lane_write_ctrl #(.LANES(LANES), .LANE_BITS(LANE_BITS)) i_lane_write_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr_load(addr_load),
        .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gwr_n(gwr_n),
        .bwgate_n(bwgate_n), .bsel_n(bsel_n), .wr_din(wr_din), .wr_par(wr_par),
        .oe_n(oe_n), .lane_wr(lane_wr), .sel(sel), .lane_data(lane_data),
        .clk_en(clk_en), .drv_en(drv_en)
    );

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // R4 packing model: lane i = {par[i], din[8i+7:8i]}
    function automatic logic [DATA_W-1:0] pack(input logic [31:0] d, input logic [3:0] p);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            for (int b = 0; b < 8; b++) r[i*9 + b] = d[i*8 + b];
            r[i*9 + 8] = p[i];
        end
        return r;
    endfunction

    task automatic step(input string tag, input logic ld, input logic c_n, input logic c_hi,
                        input logic c_lon, input logic gw, input logic gate, input logic [3:0] bs,
                        input logic [31:0] d, input logic [3:0] p, input logic oe, input logic slp);
        exp_t e;
        logic se;
        logic [3:0] raw;
        @(negedge clk);
        addr_load = ld; ce_n = c_n; cs_hi = c_hi; cs_lo_n = c_lon;
        gwr_n = gw; bwgate_n = gate; bsel_n = bs; wr_din = d; wr_par = p;
        oe_n = oe; sleep = slp;
        if (!slp) begin
            se = ld ? (!c_n && c_hi && !c_lon) : m_sel;
            if (!gw) raw = 4'hF;
            else if (!gate) raw = ~bs;
            else raw = 4'h0;
            m_sel  = se;
            m_mask = se ? raw : 4'h0;
            m_data = pack(d, p);
        end
        e.tag  = tag;
        e.mask = m_mask;
        e.sel  = m_sel;
        e.data = m_data;
        e.drv  = !oe && m_sel && (m_mask == 4'h0);
        e.cen  = !slp;
        q.push_back(e);
    endtask

    // Monitor: compare 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "lane_wr",   64'(lane_wr),   64'(e.mask));
            cmp(e.tag, "sel",       64'(sel),       64'(e.sel));
            cmp(e.tag, "lane_data", 64'(lane_data), 64'(e.data));
            cmp(e.tag, "drv_en",    64'(drv_en),    64'(e.drv));
            cmp(e.tag, "clk_en",    64'(clk_en),    64'(e.cen));
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #3;
        // R10 reset state
        cmp("R10", "lane_wr", 64'(lane_wr), 64'h0);
        cmp("R10", "sel", 64'(sel), 64'h0);
        cmp("R10", "lane_data", 64'(lane_data), 64'h0);
        oe_n = 1'b0; #1;
        cmp("R10", "drv_en", 64'(drv_en), 64'h0);
        oe_n = 1'b1;
        @(negedge clk); rst_n = 1'b1;

        // tag, ld, ce_n, cs_hi, cs_lo_n, gw_n, gate_n, bsel_n, din, par, oe_n, sleep
        step("R1_sel_gw",   1, 0,1,0, 0,1,4'hF, 32'h11223344, 4'h5, 0, 0);
        step("R1_override", 0, 0,1,0, 0,0,4'hF, 32'hA5A5A5A5, 4'hA, 0, 0);
        step("R2_1010",     0, 0,1,0, 1,0,4'b1010, 32'hDEADBEEF, 4'h3, 0, 0);
        step("R2_0111",     0, 0,1,0, 1,0,4'b0111, 32'h01020304, 4'h8, 0, 0);
        step("R2_none",     0, 0,1,0, 1,0,4'b1111, 32'h0, 4'h0, 0, 0);
        step("R3_blocked",  0, 0,1,0, 1,1,4'b0000, 32'hFFFFFFFF, 4'hF, 0, 0);
        step("R6_oe_high",  0, 0,1,0, 1,1,4'b0000, 32'h80000001, 4'h1, 1, 0);
        step("R5_wr_drv",   0, 0,1,0, 1,0,4'b1110, 32'h12345678, 4'h2, 0, 0);
        // R9 sleep freezes state while inputs move
        step("R9_sleep_a",  1, 1,0,1, 0,0,4'h0, 32'hCAFEF00D, 4'hC, 0, 1);
        step("R9_sleep_b",  0, 0,1,0, 1,1,4'hF, 32'h0BADC0DE, 4'h6, 0, 1);
        step("R9_wake",     0, 0,1,0, 1,1,4'hF, 32'h55AA55AA, 4'h9, 0, 0);
        // R7 each select input alone deselects; R8 no write while deselected
        step("R7_ce",       1, 1,1,0, 0,1,4'hF, 32'h1, 4'h1, 0, 0);
        step("R8_desel_gw", 0, 0,1,0, 0,0,4'h0, 32'h2, 4'h2, 0, 0);
        step("R7_reload",   1, 0,1,0, 1,1,4'hF, 32'h3, 4'h3, 0, 0);
        step("R7_cshi",     1, 0,0,0, 0,1,4'hF, 32'h4, 4'h4, 0, 0);
        step("R7_reload2",  1, 0,1,0, 1,1,4'hF, 32'h5, 4'h5, 0, 0);
        step("R7_cslo",     1, 0,1,1, 0,1,4'hF, 32'h6, 4'h6, 0, 0);
        step("R8_hold_off", 0, 0,1,0, 1,0,4'h0, 32'h7, 4'h7, 0, 0);
        step("R7_reload3",  1, 0,1,0, 1,1,4'hF, 32'h8, 4'h8, 0, 0);
        step("R7_hold_on",  0, 1,0,1, 1,0,4'b1100, 32'h9, 4'h9, 0, 0);
        step("R4_pattern",  0, 1,0,1, 1,1,4'hF, 32'hF0E1D2C3, 4'b0110, 0, 0);
        step("R6_idle",     0, 1,0,1, 1,1,4'hF, 32'h0, 4'h0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule